// File: doc/BRIEF.md
# Raster Timing Generator with Double-Buffered Timing Registers

This block produces the line and frame timing for a pixel display: a pixel counter, a line counter, active-high horizontal and vertical sync pulses, horizontal and vertical blanking flags and a data-enable flag. Each axis is described by five fields: a reference-to-sync offset, a sync width, a back porch, an active size and a front porch. Within a line, or within a frame, the counter starts at the reference point. After the offset the sync pulse begins. The back porch follows the sync pulse, then the active region. The remaining front-porch positions close the line or frame. The offset is taken from the front porch, so it must not exceed it.

Software programs the fields through a plain register write port and reads them back through a combinational read port. Timing writes normally go to an assembly copy that does not disturb the running raster. Software sets a request bit, and the block then copies the assembly set into the active set at the first pixel of the next vertical blanking interval. The request bit stays readable as 1 until the copy has happened. A request handler tracks this with two states. `C_IDLE` moves to `C_ARMED` when a request is written. `C_ARMED` returns to `C_IDLE` on the transfer. A transfer happens when the vertical active region ends, or on the next clock if the generator is stopped. If a new request is written in the transfer cycle, the handler stays in `C_ARMED`.

Top module: `rtg_top`

## Requirements
- R1: After reset both copies hold the minimum raster (horizontal offset 0, sync 1, back porch 20, active 16, front porch 1; vertical offset 1, sync 1, back porch 0, active 16, front porch 2). The generator is stopped, both counters read 0, hsync, vsync and de are low, and the request bit reads 0.
- R2: Each timing word carries the horizontal field in bits 15:0 and the vertical field in bits 31:16. The timing words sit at these addresses: 0 offset, 1 sync width, 2 back porch, 3 front porch, 4 active size. Address 8 bit 0 is the transfer request, address 9 selects copies, and address 10 bit 0 runs the generator. Reads of other addresses return 0.
- R3: A line lasts active + front porch + back porch + sync width pixels, and the pixel counter runs 0 to that total minus 1. The line counter advances once per line wrap, and a frame holds the same sum of vertical fields in lines.
- R4: hsync is high for pixel positions from the offset up to the offset plus the sync width. vsync is high for line positions defined the same way. Both are active high.
- R5: de is high only when the pixel position and the line position both lie in [offset+sync+back porch, offset+sync+back porch+active). hblank and vblank are high outside the respective active region.
- R6: With address 9 bit 0 clear, timing writes change only the assembly copy. The active copy and the raster are unchanged until a transfer.
- R7: Writing 1 to address 8 bit 0 sets the request bit. It reads back 1 until the transfer and 0 afterwards. Writing 0 has no effect.
- R8: While running, the transfer happens at the clock edge that ends the first pixel of the line just after the last active line. On that edge the request bit clears. The first read after the transfer therefore shows pixel 1 of that line. A request written in the transfer cycle stays pending.
- R9: Address 9 bit 0 set sends timing writes straight to the active copy, leaving the assembly copy unchanged. Address 9 bit 1 set makes timing reads return the active copy.
- R10: With address 10 bit 0 clear, both counters are held at 0, sync and de are low and blanking is high. A pending request is transferred on the next clock.
- R11: A sync width or active size of 0 behaves as 1.
- R12: The minimum raster runs correctly: a 38-pixel by 19-line frame with 256 data-enable pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 2*FW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 2*FW | Register read data, combinational |
| h_count | output | FW+2 | Pixel position within the line |
| v_count | output | FW+2 | Line position within the frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| hblank | output | 1 | Outside the horizontal active region |
| vblank | output | 1 | Outside the vertical active region |
| de | output | 1 | Data enable |

## Verification
The hardest behaviour to pin down from the ports is the exact cycle of the transfer. It happens only once per frame and depends on the old line count, not the new one. The stimulus reprograms the assembly copy at a known frame start and writes the request. It then reads the request bit on every cycle, recording the counters at the first read of 0, which must be pixel 1 of the first blanking line of the old raster. Full frames are then measured by a monitor that counts data-enable, sync and frame-length cycles and locates the first active pixel and the sync starts.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    // register addresses
    localparam int A_REF    = 0;
    localparam int A_SYNC   = 1;
    localparam int A_BACK   = 2;
    localparam int A_FRONT  = 3;
    localparam int A_ACT    = 4;
    localparam int A_COMMIT = 8;
    localparam int A_ACCESS = 9;
    localparam int A_RUN    = 10;
    localparam int NREG     = 5;

    typedef enum logic {
        C_IDLE,
        C_ARMED
    } cstate_e;
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis #(
    parameter int FW = 16,
    localparam int CW = FW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [FW-1:0] rts,
    input  logic [FW-1:0] sw,
    input  logic [FW-1:0] bp,
    input  logic [FW-1:0] fp,
    input  logic [FW-1:0] act,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          sync_o,
    output logic          act_o
);
    logic [FW-1:0] sw1, act1;
    logic [CW-1:0] total, sync_end, act_beg, act_end;

    always_comb begin
        sw1      = (sw == '0)  ? FW'(1) : sw;
        act1     = (act == '0) ? FW'(1) : act;
        total    = CW'(act1) + CW'(fp) + CW'(bp) + CW'(sw1);
        sync_end = CW'(rts) + CW'(sw1);
        act_beg  = sync_end + CW'(bp);
        act_end  = act_beg + CW'(act1);
    end

    assign wrap = step && (cnt >= total - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + CW'(1);
    end

    assign sync_o = run && (cnt >= CW'(rts)) && (cnt < sync_end);
    assign act_o  = run && (cnt >= act_beg) && (cnt < act_end);
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int FW = 16,
    parameter int AW = 4,
    localparam int DW = 2 * FW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic                     vbl_start,
    output logic [NREG-1:0][DW-1:0]  act_words,
    output logic                     run_en,
    output logic                     pend
);
    localparam logic [NREG-1:0][DW-1:0] RST_WORDS = {
        {FW'(16), FW'(16)},   // active size
        {FW'(2),  FW'(1)},    // front porch
        {FW'(0),  FW'(20)},   // back porch
        {FW'(1),  FW'(1)},    // sync width
        {FW'(1),  FW'(0)}     // reference-to-sync
    };

    logic [NREG-1:0][DW-1:0] asm_q, act_q;
    logic    wr_to_act, rd_from_act, run_q;
    cstate_e st_q, st_d;
    logic    req_wr, xfer;

    assign req_wr = wr_en && (wr_addr == AW'(A_COMMIT)) && wr_data[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= C_IDLE;
        else        st_q <= st_d;
    end

    // next state and transfer strobe
    always_comb begin
        st_d = st_q;
        xfer = 1'b0;
        unique case (st_q)
            C_IDLE: begin
                if (req_wr) st_d = C_ARMED;
            end
            C_ARMED: begin
                if (!run_q || vbl_start) begin
                    xfer = 1'b1;
                    if (!req_wr) st_d = C_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q       <= RST_WORDS;
            act_q       <= RST_WORDS;
            wr_to_act   <= 1'b0;
            rd_from_act <= 1'b0;
            run_q       <= 1'b0;
        end else begin
            if (xfer) act_q <= asm_q;
            if (wr_en) begin
                for (int i = 0; i < NREG; i++) begin
                    if (wr_addr == AW'(i)) begin
                        if (wr_to_act) act_q[i] <= wr_data;
                        else           asm_q[i] <= wr_data;
                    end
                end
                if (wr_addr == AW'(A_ACCESS)) {rd_from_act, wr_to_act} <= wr_data[1:0];
                if (wr_addr == AW'(A_RUN))    run_q <= wr_data[0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = rd_from_act ? act_q[i] : asm_q[i];
        end
        if (rd_addr == AW'(A_COMMIT)) rd_data[0]   = (st_q == C_ARMED);
        if (rd_addr == AW'(A_ACCESS)) rd_data[1:0] = {rd_from_act, wr_to_act};
        if (rd_addr == AW'(A_RUN))    rd_data[0]   = run_q;
    end

    assign act_words = act_q;
    assign run_en    = run_q;
    assign pend      = (st_q == C_ARMED);
endmodule

// File: rtl/rtg_top.sv
module rtg_top
    import rtg_pkg::*;
#(
    parameter int FW = 16,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [2*FW-1:0]   wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [2*FW-1:0]   rd_data,
    output logic [FW+1:0]     h_count,
    output logic [FW+1:0]     v_count,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              de
);
    localparam int DW = 2 * FW;

    logic [NREG-1:0][DW-1:0] act_words;
    logic run_en, pend, vbl_start;
    logic h_wrap, v_wrap, h_sync, v_sync, h_act, v_act, v_act_q;

    rtg_regs #(.FW(FW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .vbl_start(vbl_start), .act_words(act_words),
        .run_en(run_en), .pend(pend)
    );

    rtg_axis #(.FW(FW)) u_h (
        .clk(clk), .rst_n(rst_n), .run(run_en), .step(run_en),
        .rts(act_words[A_REF][FW-1:0]),   .sw(act_words[A_SYNC][FW-1:0]),
        .bp(act_words[A_BACK][FW-1:0]),   .fp(act_words[A_FRONT][FW-1:0]),
        .act(act_words[A_ACT][FW-1:0]),
        .cnt(h_count), .wrap(h_wrap), .sync_o(h_sync), .act_o(h_act)
    );

    rtg_axis #(.FW(FW)) u_v (
        .clk(clk), .rst_n(rst_n), .run(run_en), .step(h_wrap),
        .rts(act_words[A_REF][DW-1:FW]),  .sw(act_words[A_SYNC][DW-1:FW]),
        .bp(act_words[A_BACK][DW-1:FW]),  .fp(act_words[A_FRONT][DW-1:FW]),
        .act(act_words[A_ACT][DW-1:FW]),
        .cnt(v_count), .wrap(v_wrap), .sync_o(v_sync), .act_o(v_act)
    );

    // end of the vertical active region marks the transfer point
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_act_q <= 1'b0;
        else        v_act_q <= v_act;
    end
    assign vbl_start = v_act_q && !v_act;

    assign hsync  = h_sync;
    assign vsync  = v_sync;
    assign hblank = !h_act;
    assign vblank = !v_act;
    assign de     = h_act && v_act;
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
    parameter int AW = 4,
    parameter int CW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          wr_bit,
    input logic          run,
    input logic          pend,
    input logic          v_wrap,
    input logic [CW-1:0] h_count,
    input logic [CW-1:0] v_count,
    input logic          hsync,
    input logic          vsync,
    input logic          de
);
    // R7
    req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(8) && wr_bit) |=> pend);

    // R8
    pend_clears_at_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> ($past(!run) || $past(h_count) == '0));

    // R10
    stop_holds_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (h_count == '0 && v_count == '0));

    // R3
    pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && h_count != '0) |-> h_count == $past(h_count) + CW'(1));

    // R3
    line_moves_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && v_count != $past(v_count)) |-> h_count == '0);

    // R3
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && v_wrap) |=> v_count == '0);

    // R5
    sync_not_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync || vsync) |-> !de);
endmodule

bind rtg_top rtg_chk #(.AW(AW), .CW(FW + 2)) i_rtg_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit(wr_data[0]), .run(run_en), .pend(pend), .v_wrap(v_wrap),
    .h_count(h_count), .v_count(v_count),
    .hsync(hsync), .vsync(vsync), .de(de)
);

// File: tb/test_rtg_top.sv
module test_rtg_top;
    localparam int FW = 16;
    localparam int AW = 4;
    localparam int DW = 2 * FW;
    localparam int CW = FW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] h_count, v_count;
    logic          hsync, vsync, hblank, vblank, de;

    always #5 clk = ~clk;

    rtg_top #(.FW(FW), .AW(AW)) i_rtg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .h_count(h_count), .v_count(v_count), .hsync(hsync), .vsync(vsync),
        .hblank(hblank), .vblank(vblank), .de(de)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string tag;
        int len, nde, nhs, nvs, de_h, de_v, hs_h, vs_v;
    } frame_t;

    frame_t exp_q[$];
    int pushed = 0;
    int served = 0;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_addr = AW'(a);
        #1 d = rd_data;
    endtask

    function automatic int one_min(int x);
        return (x == 0) ? 1 : x;
    endfunction

    // driver: push the expected shape of the next full frame, wait for the monitor
    task automatic expect_frame(string tag, logic [DW-1:0] r, logic [DW-1:0] s,
                                logic [DW-1:0] b, logic [DW-1:0] f, logic [DW-1:0] a);
        frame_t e;
        int hr, hs, hb, hf, ha, vr, vs, vb, vf, va, ht, vt;
        hr = int'(r[15:0]); vr = int'(r[31:16]);
        hs = one_min(int'(s[15:0])); vs = one_min(int'(s[31:16]));
        hb = int'(b[15:0]); vb = int'(b[31:16]);
        hf = int'(f[15:0]); vf = int'(f[31:16]);
        ha = one_min(int'(a[15:0])); va = one_min(int'(a[31:16]));
        ht = ha + hf + hb + hs;
        vt = va + vf + vb + vs;
        e.tag = tag;
        e.len = ht * vt;  e.nde = ha * va;
        e.nhs = hs * vt;  e.nvs = vs * ht;
        e.de_h = hr + hs + hb; e.de_v = vr + vs + vb;
        e.hs_h = hr; e.vs_v = vr;
        exp_q.push_back(e);
        pushed++;
        wait (served == pushed);
    endtask

    // monitor: measure one full frame per expected item
    int m_len, m_de, m_hs, m_vs, m_deh, m_dev, m_hsh, m_vsv;
    bit m_fde, m_fhs, m_fvs;
    initial begin
        frame_t e;
        forever begin
            wait (pushed > served);
            @(negedge clk);
            while (!(h_count == '0 && v_count == '0)) @(negedge clk);
            m_len = 0; m_de = 0; m_hs = 0; m_vs = 0;
            m_deh = -1; m_dev = -1; m_hsh = -1; m_vsv = -1;
            m_fde = 0; m_fhs = 0; m_fvs = 0;
            do begin
                if (de) begin
                    m_de++;
                    if (!m_fde) begin m_fde = 1; m_deh = int'(h_count); m_dev = int'(v_count); end
                end
                if (hsync) begin
                    m_hs++;
                    if (!m_fhs && v_count == '0) begin m_fhs = 1; m_hsh = int'(h_count); end
                end
                if (vsync) begin
                    m_vs++;
                    if (!m_fvs) begin m_fvs = 1; m_vsv = int'(v_count); end
                end
                m_len++;
                @(negedge clk);
            end while (!(h_count == '0 && v_count == '0));
            e = exp_q.pop_front();
            check({e.tag, " R3 frame length"}, m_len, e.len);
            check({e.tag, " R5 de count"}, m_de, e.nde);
            check({e.tag, " R4 hsync count"}, m_hs, e.nhs);
            check({e.tag, " R4 vsync count"}, m_vs, e.nvs);
            check({e.tag, " R5 first de pixel"}, m_deh, e.de_h);
            check({e.tag, " R5 first de line"}, m_dev, e.de_v);
            check({e.tag, " R4 hsync start"}, m_hsh, e.hs_h);
            check({e.tag, " R4 vsync start"}, m_vsv, e.vs_v);
            served++;
        end
    end

    task automatic wait_commit(string tag, output int hh, output int vv);
        int guard;
        guard = 0;
        hh = -1; vv = -1;
        rd_addr = AW'(8);
        forever begin
            @(negedge clk);
            #1;
            if (!rd_data[0]) begin hh = int'(h_count); vv = int'(v_count); break; end
            guard++;
            if (guard > 20000) begin check({tag, " transfer never seen"}, 1, 0); break; end
        end
    endtask

    initial begin
        #1_500_000;
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [DW-1:0] d;
        int hh, vv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 h_count", int'(h_count), 0);
        check("R1 v_count", int'(v_count), 0);
        check("R1 sync/de low", {hsync, vsync, de}, 0);
        rd(0, d);  check("R1 R2 assembly offset word", d, 32'h0001_0000);
        rd(4, d);  check("R1 R2 assembly active word", d, 32'h0010_0010);
        rd(8, d);  check("R1 request bit", d, 0);
        rd(12, d); check("R2 unmapped read", d, 0);
        wr(9, 32'h2);
        rd(3, d);  check("R1 active front word", d, 32'h0002_0001);
        wr(9, 32'h0);

        // R12 minimum raster
        wr(10, 32'h1);
        expect_frame("R12 min raster", 32'h0001_0000, 32'h0001_0001, 32'h0000_0014,
                     32'h0002_0001, 32'h0010_0010);

        // R6 writes land in the assembly copy
        wr(0, 32'h0001_0002);
        wr(1, 32'h0002_0003);
        wr(2, 32'h0003_0004);
        wr(3, 32'h0004_0005);
        wr(4, 32'h0008_000A);
        wr(9, 32'h2);
        rd(0, d); check("R6 active offset unchanged", d, 32'h0001_0000);
        wr(9, 32'h0);
        rd(0, d); check("R6 assembly offset written", d, 32'h0001_0002);
        wr(8, 32'h0);
        rd(8, d); check("R7 writing 0 ignored", d, 0);
        wr(8, 32'h1);
        rd(8, d); check("R7 request reads 1", d, 1);
        // R8 transfer at first pixel of old vertical blanking (line 18 of min raster)
        wait_commit("R8", hh, vv);
        check("R8 transfer pixel", hh, 1);
        check("R8 transfer line", vv, 18);
        wr(9, 32'h2);
        rd(0, d); check("R6 R8 active offset after transfer", d, 32'h0001_0002);
        wr(9, 32'h0);
        expect_frame("R6 R8 new raster", 32'h0001_0002, 32'h0002_0003, 32'h0003_0004,
                     32'h0004_0005, 32'h0008_000A);

        // R11 zero sync width and zero active size
        wr(1, 32'h0002_0000);
        wr(4, 32'h0000_000A);
        wr(8, 32'h1);
        wait_commit("R11", hh, vv);
        expect_frame("R11 zero fields", 32'h0001_0002, 32'h0002_0000, 32'h0003_0004,
                     32'h0004_0005, 32'h0000_000A);

        // R9 write straight to active copy
        wr(9, 32'h1);
        wr(3, 32'h0004_0007);
        wr(9, 32'h3);
        rd(3, d); check("R9 active front written", d, 32'h0004_0007);
        wr(9, 32'h1);
        rd(3, d); check("R9 assembly front untouched", d, 32'h0004_0005);
        expect_frame("R9 direct raster", 32'h0001_0002, 32'h0002_0000, 32'h0003_0004,
                     32'h0004_0007, 32'h0000_000A);

        // R10 stopped generator
        wr(9, 32'h0);
        wr(10, 32'h0);
        repeat (3) @(negedge clk);
        check("R10 counters held", int'({h_count, v_count}), 0);
        check("R10 sync/de low", {hsync, vsync, de}, 0);
        check("R10 blanking high", {hblank, vblank}, 3);
        wr(0, 32'h0001_0001);
        wr(8, 32'h1);
        rd(8, d); check("R10 request applied next clock", d, 0);
        wr(9, 32'h2);
        rd(0, d); check("R10 active offset after stopped transfer", d, 32'h0001_0001);

        summary();
    end
endmodule